// File: doc/BRIEF.md
# Resistor-String DAC Code Path with Direct-Drive Test Bypass

This block forms the 5-bit active-low code that steers a resistor-string DAC in a speech synthesizer. It also expands that code into 32 one-hot tap enables, one for each tap on the resistor string. In normal operation, the sample value from the arithmetic unit is captured into a register only on clock edges that carry a sample-rate strobe. The register contents then drive the code.

A pin-level test condition sets up a second path. TST1 must be high, and both VREF and START must be low. Under that condition, the low five bits of the external 8-bit data bus drive the code through combinational logic alone. No clock edge is needed, so the analog output can be measured one code at a time while the bus sweeps. Once the test condition is removed, the code comes from the sample register again.

Top module: `dac_code_path`

## Requirements
- R1: `dac_code_n_o` is the bitwise inverse of the selected 5-bit code value, so code value 0 appears as 5'b11111 and value 31 appears as 5'b00000.
- R2: Exactly one bit of `tap_en_o` is high in every cycle.
- R3: Test mode is active only when `tst1_i`=1, `vref_i`=0 and `start_i`=0. With `vref_i` or `start_i` high, or with `tst1_i` low, the code comes from the sample register.
- R4: In normal mode, a rising clock edge with `sample_stb_i`=1 and `rst_i`=0 loads `sample_i` into the register. The new code is visible right after that edge.
- R5: In normal mode, the register and the code hold their value on any edge with `sample_stb_i`=0.
- R6: Bit N of `tap_en_o` is high exactly when the code value is N, where N is the bitwise inverse of `dac_code_n_o`.
- R7: A synchronous reset (`rst_i`=1 at a rising edge) clears the register to code value 0. In normal mode this gives `dac_code_n_o`=5'b11111 and `tap_en_o`=1. Reset takes priority over the strobe.
- R8: In test mode, `dac_code_n_o` equals the inverse of `data_bus_i[4:0]` without waiting for a clock edge. Bits `data_bus_i[7:5]` have no effect.
- R9: When test mode ends, the code returns at once to the register contents. No new strobe is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sample_i | input | 5 | Computed sample code from the arithmetic unit |
| sample_stb_i | input | 1 | Sample-rate strobe; load enable for the register |
| data_bus_i | input | 8 | External data bus; low five bits drive the code in test mode |
| tst1_i | input | 1 | Test pin; high is required for test mode |
| vref_i | input | 1 | Reference pin; must be low for test mode |
| start_i | input | 1 | Start pin; must be low for test mode |
| dac_code_n_o | output | 5 | Active-low DAC code |
| tap_en_o | output | 32 | One-hot resistor tap enables, active high |

## Verification
The assertions assume that the pins and the bus are stable at each rising edge, because the test path is only observed at clock edges. They also assume that no strobe arrives while test mode is held, since the register contents are not visible then. The stimulus changes every input half a cycle away from the rising edge. Strobes are applied only in normal mode. Mid-cycle bus changes in test mode are checked combinationally before the next edge, so the unclocked path is exercised without relying on a clock.

// File: rtl/dac_code_pkg.sv
package dac_code_pkg;
    localparam int unsigned CODE_W = 5;
    localparam int unsigned BUS_W  = 8;
    localparam int unsigned NTAP   = 1 << CODE_W;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t level;
    } smp_state_t;
endpackage

// File: rtl/dac_sample_reg.sv
module dac_sample_reg
    import dac_code_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  load_i,
    input  code_t level_i,
    output code_t level_o
);
    smp_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.level = level_i;
        end
        if (rst_i) begin
            state_d.level = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign level_o = state_q.level;

    AST_LOAD_ON_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(load_i)) |-> (level_o == $past(level_i))) // R4
        else $error("sample register missed a strobed load");

    AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(load_i)) |-> $stable(level_o)) // R5
        else $error("sample register changed without strobe");

    AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (level_o == '0)) // R7
        else $error("sample register not cleared by reset");
endmodule

// File: rtl/dac_code_select.sv
module dac_code_select
    import dac_code_pkg::*;
(
    input  logic             tst1_i,
    input  logic             vref_i,
    input  logic             start_i,
    input  logic [BUS_W-1:0] bus_i,
    input  code_t            held_i,
    output logic             test_mode_o,
    output code_t            level_o,
    output code_t            code_n_o
);
    logic  test_mode;
    code_t chosen;

    always_comb begin
        test_mode = tst1_i && !vref_i && !start_i;
        chosen    = test_mode ? bus_i[CODE_W-1:0] : held_i;
    end

    assign test_mode_o = test_mode;
    assign level_o     = chosen;
    assign code_n_o    = ~chosen;
endmodule

// File: rtl/dac_tap_decoder.sv
module dac_tap_decoder
    import dac_code_pkg::*;
(
    input  code_t             level_i,
    output logic [NTAP-1:0]   tap_o
);
    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        assign tap_o[t] = (level_i == code_t'(t));
    end
endmodule

// File: rtl/dac_code_path.sv
module dac_code_path
    import dac_code_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic [4:0]  sample_i,
    input  logic        sample_stb_i,
    input  logic [7:0]  data_bus_i,
    input  logic        tst1_i,
    input  logic        vref_i,
    input  logic        start_i,
    output logic [4:0]  dac_code_n_o,
    output logic [31:0] tap_en_o
);
    code_t held_level;
    code_t sel_level;
    logic  test_mode;

    dac_sample_reg u_sreg (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (sample_stb_i),
        .level_i (sample_i),
        .level_o (held_level)
    );

    dac_code_select u_sel (
        .tst1_i      (tst1_i),
        .vref_i      (vref_i),
        .start_i     (start_i),
        .bus_i       (data_bus_i),
        .held_i      (held_level),
        .test_mode_o (test_mode),
        .level_o     (sel_level),
        .code_n_o    (dac_code_n_o)
    );

    dac_tap_decoder u_dec (
        .level_i (sel_level),
        .tap_o   (tap_en_o)
    );

    AST_TAP_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(tap_en_o) == 1) // R2
        else $error("tap enables not one-hot");

    AST_TAP_MATCHES_CODE: assert property (@(posedge clk_i) disable iff (rst_i)
        tap_en_o[~dac_code_n_o]) // R6
        else $error("tap enable does not match code");

    AST_TEST_DIRECT: assert property (@(posedge clk_i) disable iff (rst_i)
        (tst1_i && !vref_i && !start_i) |-> (dac_code_n_o == ~data_bus_i[4:0])) // R8
        else $error("test mode code does not follow bus");

    AST_UPPER_BUS_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
        (test_mode && $past(test_mode) && !$past(rst_i)
         && (data_bus_i[4:0] == $past(data_bus_i[4:0]))
         && (data_bus_i[7:5] != $past(data_bus_i[7:5]))) |-> $stable(dac_code_n_o)) // R8
        else $error("upper bus bits changed the code");

    AST_NORMAL_FROM_REG: assert property (@(posedge clk_i) disable iff (rst_i)
        !(tst1_i && !vref_i && !start_i) |-> (dac_code_n_o == ~held_level)) // R3
        else $error("normal mode code not taken from register");

    AST_LEAVE_TEST: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(test_mode) && !$past(rst_i) && !$past(sample_stb_i))
        |-> (dac_code_n_o == ~$past(held_level))) // R9
        else $error("code did not return to register on test exit");
endmodule

// File: tb/dac_code_path_tb.sv
module dac_code_path_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  sample;
    logic        stb;
    logic [7:0]  bus;
    logic        tst1, vref, start;
    logic [4:0]  code_n;
    logic [31:0] tap;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dac_code_path dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .sample_i     (sample),
        .sample_stb_i (stb),
        .data_bus_i   (bus),
        .tst1_i       (tst1),
        .vref_i       (vref),
        .start_i      (start),
        .dac_code_n_o (code_n),
        .tap_en_o     (tap)
    );

    typedef struct packed {
        logic       t1;
        logic       vr;
        logic       st;
        logic [7:0] bus;
        logic [4:0] smp;
        logic       stb;
        logic [4:0] exp_lvl;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,8'h00,5'd5 ,1'b1,5'd5 },  // R4 load
        '{1'b0,1'b0,1'b0,8'h00,5'd9 ,1'b0,5'd5 },  // R5 hold
        '{1'b1,1'b0,1'b0,8'hE3,5'd9 ,1'b0,5'd3 },  // R8 upper bits ignored
        '{1'b1,1'b1,1'b0,8'h1F,5'd9 ,1'b0,5'd5 },  // R3 vref blocks test
        '{1'b1,1'b0,1'b1,8'h1F,5'd9 ,1'b0,5'd5 },  // R3 start blocks test
        '{1'b0,1'b0,1'b0,8'h1F,5'd9 ,1'b0,5'd5 },  // R3 tst1 low
        '{1'b0,1'b0,1'b0,8'h00,5'd31,1'b1,5'd31},  // R4 top code
        '{1'b0,1'b0,1'b0,8'h00,5'd0 ,1'b1,5'd0 },  // R4 bottom code
        '{1'b1,1'b0,1'b0,8'h1F,5'd0 ,1'b0,5'd31},  // R8 top tap
        '{1'b1,1'b0,1'b0,8'h00,5'd0 ,1'b0,5'd0 },  // R8 bottom tap
        '{1'b0,1'b0,1'b0,8'h00,5'd7 ,1'b0,5'd0 },  // R9 return
        '{1'b0,1'b0,1'b0,8'h00,5'd17,1'b1,5'd17},  // R4
        '{1'b1,1'b0,1'b0,8'hA4,5'd17,1'b0,5'd4 },  // R8
        '{1'b0,1'b0,1'b0,8'hA4,5'd2 ,1'b0,5'd17}   // R9 return, R5
    };

    task automatic check(input string req, input logic [4:0] exp_lvl);
        logic [31:0] exp_tap;
        exp_tap = 32'd1 << exp_lvl;
        n_chk++;
        if (code_n !== ~exp_lvl || tap !== exp_tap) begin
            n_bad++;
            $display("FAIL %s: code_n=%b tap=%h expected code_n=%b tap=%h",
                     req, code_n, tap, ~exp_lvl, exp_tap);
        end
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; sample = '0; stb = 1'b0; bus = '0;
        tst1 = 1'b0; vref = 1'b0; start = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R7 reset state", 5'd0);   // R7
        check("R1 active low idle", 5'd0); // R1

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            tst1 = VECS[i].t1; vref = VECS[i].vr; start = VECS[i].st;
            bus = VECS[i].bus; sample = VECS[i].smp; stb = VECS[i].stb;
            @(posedge clk);
            #1;
            check($sformatf("R1/R2/R6 vector %0d", i), VECS[i].exp_lvl);
        end

        // R8: unclocked path, bus change observed before next edge
        @(negedge clk);
        stb = 1'b0; tst1 = 1'b1; vref = 1'b0; start = 1'b0; bus = 8'h0A;
        #1 check("R8 combinational a", 5'd10);
        bus = 8'h15;
        #1 check("R8 combinational b", 5'd21);
        bus = 8'hF5;
        #1 check("R8 upper bits no effect", 5'd21);

        // R9: leave test mode mid-cycle, register value 17 returns at once
        tst1 = 1'b0;
        #1 check("R9 immediate return", 5'd17);

        // R7: reset wins over a strobe
        @(negedge clk);
        rst = 1'b1; stb = 1'b1; sample = 5'd12;
        @(posedge clk); #1;
        rst = 1'b0; stb = 1'b0;
        check("R7 reset over strobe", 5'd0);

        // R8 during reset: test path ignores clocked reset
        @(negedge clk);
        rst = 1'b1; tst1 = 1'b1; bus = 8'h09;
        #1 check("R8 test path in reset", 5'd9);
        @(posedge clk); #1;
        check("R8 test path after reset edge", 5'd9);
        @(negedge clk);
        rst = 1'b0; tst1 = 1'b0;
        #1 check("R7 cleared register visible", 5'd0);

        // R5: several edges without strobe keep the code
        @(negedge clk);
        sample = 5'd25; stb = 1'b1;
        @(posedge clk); #1;
        stb = 1'b0; sample = 5'd3;
        repeat (4) @(posedge clk);
        #1 check("R5 multi-cycle hold", 5'd25);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule